// File: doc/BRIEF.md
# H-Bridge Gate Controller with Short Protection

This block is the digital core of a full-bridge driver that switches four external N-channel transistors: a high-side and a low-side switch on each of the two bridge outputs. An enable, a direction bit and a PWM bit are decoded into four gate commands. Each half-bridge has its own break-before-make interval, so that the two switches of one output are never on together.

Two comparator flags report whether each bridge output is above its threshold. A conducting high-side switch whose output stays low is taken to be shorted to ground. A conducting low-side switch whose output stays high is taken to be shorted to the supply. After a programmable qualification time, only the faulted switch is latched off. The latch is released by any change on the direction or PWM input. Thermal, overvoltage and undervoltage flags force every gate off while they are present. An active-low diagnostic output reports any protection event.

All control, comparator and fault inputs pass through a synchronizer of `SYNC_STAGES` flip-flops. The gate and diagnostic outputs are registered.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `en_i` is 0, all four gate outputs are 0. The diagnostic output is unaffected by `en_i`.
- R2: With `en_i`=1, `pwm_i`=1 and `dir_i`=1, the requested switches are high-side 1 and low-side 2. With `dir_i`=0 they are high-side 2 and low-side 1. With `pwm_i`=0, both low-side switches are requested and neither high-side switch is.
- R3: The two gates of one half-bridge are never 1 together. A gate rises no sooner than `DEAD_CYC`+1 cycles after its partner's gate fell; with the default of 4 this is 5 cycles.
- R4: A comparator input is 1 when its bridge output is above threshold. If a high-side gate is on and its comparator reads 0 for `SC_CYC`+1 consecutive synchronized cycles, that gate is latched off. A run of exactly `SC_CYC` cycles does not latch.
- R5: If a low-side gate is on and its comparator reads 1 for `SC_CYC`+1 consecutive synchronized cycles, that gate is latched off. A shorter run does not latch.
- R6: A short-circuit latch turns off only the faulted switch. The other three gates keep following their commands.
- R7: A latched switch stays off until `dir_i` or `pwm_i` changes value. It then follows its command again, once the other two synchronizer stages and the output register have been passed.
- R8: `diag_no` is 0 while any short-circuit latch is set. It returns to 1 one cycle after the latch clears.
- R9: While `therm_flt_i` or `ovolt_flt_i` is 1, all gates are 0 and `diag_no` is 0. When the flag clears, the gates resume their commands without any further input.
- R10: While `uvolt_flt_i` is 1, all gates are 0 and `diag_no` is 0.
- R11: With the default of 2 synchronizer stages, a change on any input reaches the gate and diagnostic outputs on the third rising clock edge after it is applied, when no dead time is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable |
| dir_i | input | 1 | Direction select |
| pwm_i | input | 1 | PWM drive level |
| cmp1_i | input | 1 | Bridge output 1 above threshold |
| cmp2_i | input | 1 | Bridge output 2 above threshold |
| therm_flt_i | input | 1 | Thermal shutdown flag |
| ovolt_flt_i | input | 1 | Overvoltage flag |
| uvolt_flt_i | input | 1 | Undervoltage flag |
| gate_hs1_o | output | 1 | High-side 1 gate on |
| gate_hs2_o | output | 1 | High-side 2 gate on |
| gate_ls1_o | output | 1 | Low-side 1 gate on |
| gate_ls2_o | output | 1 | Low-side 2 gate on |
| diag_no | output | 1 | Diagnostic, low on any fault |

## Verification
Plain command changes and fault flags show up at the outputs three edges after they are driven. A turn-on that follows a turn-off in the same half-bridge arrives five cycles after the turn-off. A sustained comparator short takes the gate off twelve edges after it is applied. After a latch clears, the diagnostic recovers one edge later than the gates. The driver drives inputs on falling edges and queues each expected output word with the exact cycle in which it is due. It also queues the word due one cycle earlier where a boundary matters, so that early and late outputs are both caught. The monitor compares only on falling edges, in the cycle each item names. The bridge outputs that feed the comparators come from a small plant model driven by the gate outputs. Shorts are injected as overrides of that model for measured numbers of cycles.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic {
    SIDE_HIGH = 1'b0,
    SIDE_LOW  = 1'b1
  } side_e;

  typedef struct packed {
    logic hs;
    logic ls;
  } hb_gate_t;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbg_halfbridge.sv
module hbg_halfbridge
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  hb_gate_t req_i,
  output hb_gate_t gate_o
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);

  logic [CW-1:0] dead_q;
  hb_gate_t      gate_q, gate_d;
  logic          dead_done;

  assign dead_done = (dead_q == CW'(DEAD_CYC));

  // turn-off is immediate; turn-on waits for the partner to be off DEAD_CYC cycles
  always_comb begin
    gate_d.hs = req_i.hs & ~req_i.ls & (gate_q.hs | (~gate_q.ls & dead_done));
    gate_d.ls = req_i.ls & ~req_i.hs & (gate_q.ls | (~gate_q.hs & dead_done));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      dead_q <= '0;
    end else begin
      gate_q <= gate_d;
      if (gate_q.hs | gate_q.ls) dead_q <= '0;
      else if (!dead_done)       dead_q <= dead_q + CW'(1);
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hbg_short_det.sv
module hbg_short_det
  import hbg_pkg::*;
#(
  parameter int unsigned SC_CYC = 8,
  parameter side_e       SIDE   = SIDE_HIGH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_on_i,
  input  logic cmp_hi_i,
  input  logic clr_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(SC_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          trip_q;
  logic          bad;

  generate
    if (SIDE == SIDE_HIGH) begin : g_hs
      assign bad = ~cmp_hi_i;   // output held low: short to ground
    end else begin : g_ls
      assign bad = cmp_hi_i;    // output held high: short to supply
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (trip_q || !(gate_on_i && bad)) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(SC_CYC)) begin
      cnt_q  <= '0;
      trip_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign trip_o = trip_q;
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEAD_CYC    = 4,
  parameter int unsigned SC_CYC      = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dir_i,
  input  logic pwm_i,
  input  logic cmp1_i,
  input  logic cmp2_i,
  input  logic therm_flt_i,
  input  logic ovolt_flt_i,
  input  logic uvolt_flt_i,
  output logic gate_hs1_o,
  output logic gate_hs2_o,
  output logic gate_ls1_o,
  output logic gate_ls2_o,
  output logic diag_no
);
  localparam int unsigned NUM_HB = 2;
  localparam int unsigned IN_W   = 3 + NUM_HB + 3;

  logic [IN_W-1:0]   raw_in, syn_in;
  logic              en_s, dir_s, pwm_s;
  logic [NUM_HB-1:0] cmp_s;
  logic [2:0]        flt_s;

  assign raw_in = {uvolt_flt_i, ovolt_flt_i, therm_flt_i, cmp2_i, cmp1_i, pwm_i, dir_i, en_i};

  hbg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (syn_in)
  );

  assign {flt_s, cmp_s, pwm_s, dir_s, en_s} = syn_in;

  // change detect on direction and PWM releases short latches
  logic dir_d, pwm_d, chg;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_d <= 1'b0;
      pwm_d <= 1'b0;
    end else begin
      dir_d <= dir_s;
      pwm_d <= pwm_s;
    end
  end
  assign chg = (dir_s ^ dir_d) | (pwm_s ^ pwm_d);

  // diagonal decode; PWM low recirculates through both low sides
  hb_gate_t [NUM_HB-1:0] cmd, req, gate;
  logic     [NUM_HB-1:0] trip_hs, trip_ls;
  logic                  run_ok;

  assign run_ok = en_s & ~|flt_s;

  always_comb begin
    cmd[0].hs = pwm_s &  dir_s;
    cmd[1].hs = pwm_s & ~dir_s;
    cmd[0].ls = ~pwm_s | ~dir_s;
    cmd[1].ls = ~pwm_s |  dir_s;
  end

  generate
    for (genvar h = 0; h < NUM_HB; h++) begin : g_hb
      assign req[h].hs = cmd[h].hs & run_ok & ~trip_hs[h];
      assign req[h].ls = cmd[h].ls & run_ok & ~trip_ls[h];

      hbg_halfbridge #(.DEAD_CYC(DEAD_CYC)) i_hb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req[h]),
        .gate_o (gate[h])
      );

      hbg_short_det #(.SC_CYC(SC_CYC), .SIDE(SIDE_HIGH)) i_sc_hs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .gate_on_i (gate[h].hs),
        .cmp_hi_i  (cmp_s[h]),
        .clr_i     (chg),
        .trip_o    (trip_hs[h])
      );

      hbg_short_det #(.SC_CYC(SC_CYC), .SIDE(SIDE_LOW)) i_sc_ls (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .gate_on_i (gate[h].ls),
        .cmp_hi_i  (cmp_s[h]),
        .clr_i     (chg),
        .trip_o    (trip_ls[h])
      );
    end
  endgenerate

  logic diag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) diag_q <= 1'b1;
    else         diag_q <= ~(|flt_s | |trip_hs | |trip_ls);
  end

  assign gate_hs1_o = gate[0].hs;
  assign gate_ls1_o = gate[0].ls;
  assign gate_hs2_o = gate[1].hs;
  assign gate_ls2_o = gate[1].ls;
  assign diag_no    = diag_q;
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic therm_flt_i,
  input logic uvolt_flt_i,
  input logic gate_hs1_o,
  input logic gate_hs2_o,
  input logic gate_ls1_o,
  input logic gate_ls2_o,
  input logic diag_no
);
  logic any_gate;
  assign any_gate = gate_hs1_o | gate_hs2_o | gate_ls1_o | gate_ls2_o;

  // R1
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i) && !$past(en_i, 2)) |=> !any_gate);

  // R3
  hb1_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hs1_o && gate_ls1_o));

  // R3
  hb2_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hs2_o && gate_ls2_o));

  // R3
  hs1_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_hs1_o) |-> (!$past(gate_ls1_o) && !$past(gate_ls1_o, 2)));

  // R3
  ls2_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_ls2_o) |-> (!$past(gate_hs2_o) && !$past(gate_hs2_o, 2)));

  // R9
  therm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_flt_i && $past(therm_flt_i) && $past(therm_flt_i, 2)) |=> (!any_gate && !diag_no));

  // R10
  uv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uvolt_flt_i && $past(uvolt_flt_i) && $past(uvolt_flt_i, 2)) |=> (!any_gate && !diag_no));
endmodule

bind hbridge_gate_ctrl hbg_chk i_hbg_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .therm_flt_i (therm_flt_i),
  .uvolt_flt_i (uvolt_flt_i),
  .gate_hs1_o  (gate_hs1_o),
  .gate_hs2_o  (gate_hs2_o),
  .gate_ls1_o  (gate_ls1_o),
  .gate_ls2_o  (gate_ls2_o),
  .diag_no     (diag_no)
);

// File: tb/test_hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module test_hbridge_gate_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 0, dir = 0, pwm = 0, therm = 0, ovolt = 0, uvolt = 0;
  logic sc1_force = 0, sc1_val = 0, sc2_force = 0, sc2_val = 0;
  logic cmp1, cmp2;
  logic hs1, hs2, ls1, ls2, diag_n;

  always #2.5 clk = ~clk;

  // plant: node is low only while its low side conducts
  assign cmp1 = sc1_force ? sc1_val : ~ls1;
  assign cmp2 = sc2_force ? sc2_val : ~ls2;

  hbridge_gate_ctrl i_hbridge_gate_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .dir_i       (dir),
    .pwm_i       (pwm),
    .cmp1_i      (cmp1),
    .cmp2_i      (cmp2),
    .therm_flt_i (therm),
    .ovolt_flt_i (ovolt),
    .uvolt_flt_i (uvolt),
    .gate_hs1_o  (hs1),
    .gate_hs2_o  (hs2),
    .gate_ls1_o  (ls1),
    .gate_ls2_o  (ls2),
    .diag_no     (diag_n)
  );

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int        due_q[$];
  logic [4:0] exp_q[$];
  string     tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // expected word {hs1,hs2,ls1,ls2,diag_n}, due d cycles from now
  task automatic expect_out(input int d, input logic [4:0] v, input string tag);
    due_q.push_back(cyc + d);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (due_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected items never compared (actual %0d, expected 0)",
               tag_q[0], due_q.size(), due_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    while (due_q.size() != 0 && due_q[0] <= cyc) begin
      logic [4:0] obs;
      logic [4:0] ex;
      string      tg;
      int         du;
      obs = {hs1, hs2, ls1, ls2, diag_n};
      du  = due_q.pop_front();
      ex  = exp_q.pop_front();
      tg  = tag_q.pop_front();
      n_run++;
      if (du != cyc || obs !== ex) begin
        n_fail++;
        $display("FAIL %s at cycle %0d: actual %b expected %b", tg, cyc, obs, ex);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected under 5000", cyc);
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    expect_out(1, 5'b00001, "R1 reset");
    step(10);

    // R2 forward drive, R11 latency
    en = 1; dir = 1; pwm = 1;
    expect_out(2, 5'b00001, "R11");
    expect_out(3, 5'b10011, "R2 fwd");
    step(10);

    // R3 high side 1 off, low side 1 waits dead time
    pwm = 0;
    expect_out(3, 5'b00011, "R3 off");
    expect_out(7, 5'b00011, "R3 wait");
    expect_out(8, 5'b00111, "R2 recirc");
    step(12);

    // R2 reverse drive with dead time on bridge 2
    dir = 0; pwm = 1;
    expect_out(3, 5'b00101, "R3 off2");
    expect_out(7, 5'b00101, "R3 wait2");
    expect_out(8, 5'b01101, "R2 rev");
    step(12);

    // R4 high side 2 short to ground
    sc2_force = 1; sc2_val = 0;
    expect_out(11, 5'b01101, "R4 qual");
    expect_out(12, 5'b00100, "R4 trip");
    step(15);
    sc2_force = 0;
    step(5);
    expect_out(1, 5'b00100, "R7 held");
    step(5);

    // R7 release by PWM change, R8 diag follows one cycle later
    pwm = 0;
    expect_out(3, 5'b00110, "R7 release");
    expect_out(4, 5'b00111, "R8 diag");
    step(10);

    // R5 low side 1 short to supply, R6 low side 2 unaffected
    sc1_force = 1; sc1_val = 1;
    expect_out(11, 5'b00111, "R5 qual");
    expect_out(12, 5'b00010, "R6 only ls1");
    step(15);
    sc1_force = 0;
    step(3);
    dir = 1;
    expect_out(3, 5'b00010, "R7 dir");
    expect_out(4, 5'b00111, "R7 dir resume");
    step(10);

    // R5 boundary: exactly SC_CYC bad cycles does not trip
    sc2_force = 1; sc2_val = 1;
    step(8);
    sc2_force = 0;
    expect_out(10, 5'b00111, "R5 boundary");
    step(15);

    // R9 thermal
    therm = 1;
    expect_out(3, 5'b00000, "R9 therm");
    step(10);
    therm = 0;
    expect_out(3, 5'b00111, "R9 recover");
    step(10);

    // R9 overvoltage
    ovolt = 1;
    expect_out(2, 5'b00111, "R11 ov");
    expect_out(3, 5'b00000, "R9 ov");
    step(10);
    ovolt = 0;
    step(10);

    // R10 undervoltage
    uvolt = 1;
    expect_out(3, 5'b00000, "R10 uv");
    step(6);
    expect_out(1, 5'b00000, "R10 hold");
    step(2);
    uvolt = 0;
    step(10);
    expect_out(1, 5'b00111, "R10 recover");
    step(5);

    // R1 enable low
    en = 0;
    expect_out(3, 5'b00001, "R1 en off");
    step(10);
    en = 1; dir = 1; pwm = 1;
    expect_out(3, 5'b10011, "R2 re-enable");
    step(10);

    step(5);
    finish_run();
  end
endmodule